// File: doc/BRIEF.md
# Region-aware bus access splitter

This block sits between a processor's load/store unit and its external bus. It takes a memory request, given as a start address, a byte count from 1 to 16 and a read/write flag, and issues it as a series of bus sub-transactions. Each sub-transaction is tagged with the configuration word of the memory region that its address falls in. The top three address bits select one of eight region configuration registers.

A configuration word sets the data bus width of its region. The request is cut into naturally aligned beats that are no wider than that width. Because every region boundary is also aligned to any bus width, a request that runs from one region into the next is always cut at the boundary. The bytes below the boundary go out under the lower region's configuration, and the rest go out under the upper region's. Requests whose start address falls in a parameterised internal window skip the region lookup: they leave as a single sub-transaction marked internal.

Software writes the configuration registers through a valid/ready write port. A write that arrives while an access is in progress is parked in a single pending slot. It is applied only after that access has finished. A further write waits at the port until the slot has drained.

Top module: `region_bus_splitter`

## Requirements
- R1: After reset, sub_valid and req_ack are low, cfg_wr_ready is high, and all configuration registers read as zero (8-bit width).
- R2: An external request is issued as consecutive beats. Each beat has length min(remaining, w - (addr mod w)), where w is 1, 2 or 4 bytes for width code cfg[1:0] = 0, 1 or 2/3. The address advances by the length of each beat.
- R3: Each external beat carries in sub_cfg the configuration register indexed by bits [31:29] of that beat's own address.
- R4: A 16-byte request at 0x1FFF_FFFE, with both region 0 and region 1 set to the 32-bit code, issues a 2-byte beat tagged with the region 0 word. It then issues 4, 4, 4 and 2 byte beats from 0x2000_0000, each tagged with the region 1 word.
- R5: A request whose start address satisfies (addr & INT_MASK) == INT_BASE is issued as one beat of the full length, with sub_internal high and sub_cfg zero, whatever the register contents.
- R6: req_ack is high only in the cycle where the request's last beat is accepted (sub_valid and sub_ready both high). The requester holds req_valid and its fields until then.
- R7: A configuration write accepted while no access is in progress affects the next request.
- R8: A configuration write accepted while an access is in progress does not change the tags of that access. It takes effect for the following request.
- R9: While a deferred write is pending, cfg_wr_ready is low. It returns high once the pending write has been applied after the access ends.
- R10: While sub_valid is high and sub_ready is low, sub_valid stays high and the beat's address and length stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request start address |
| req_len | input | 5 | Request byte count, 1 to 16 |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_ack | output | 1 | Last beat of the request accepted |
| sub_valid | output | 1 | Sub-transaction present |
| sub_ready | input | 1 | Bus accepts the sub-transaction |
| sub_addr | output | 32 | Beat address |
| sub_len | output | 5 | Beat byte count |
| sub_write | output | 1 | Beat direction |
| sub_internal | output | 1 | Beat takes the internal path |
| sub_cfg | output | 32 | Region configuration tag |
| cfg_wr_valid | input | 1 | Configuration write present |
| cfg_wr_ready | output | 1 | Configuration write accepted |
| cfg_wr_idx | input | 3 | Target region register |
| cfg_wr_data | input | 32 | New configuration word |

## Verification
Two functions can land in the same cycle: a configuration write reaching the port, and a beat being issued from the region that the write targets. The bench provokes this by holding sub_ready low in the middle of a boundary-crossing request. It then writes new words, first to the region that the current beat comes from and then to a second region. The scoreboard expects every beat of that request to carry the old words. It expects the following requests to carry the new words, and it checks that the port refuses the second write until the access has ended.

// File: rtl/region_bus_splitter.sv
module region_bus_splitter #(
  parameter int AW = 32,
  parameter int RBITS = 3,
  parameter int CW = 32,
  parameter int MAXLEN = 16,
  parameter logic [31:0] INT_BASE = 32'hFF00_0000,
  parameter logic [31:0] INT_MASK = 32'hFF00_0000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [AW-1:0]              req_addr,
  input  logic [$clog2(MAXLEN+1)-1:0] req_len,
  input  logic                       req_write,
  output logic                       req_ack,
  output logic                       sub_valid,
  input  logic                       sub_ready,
  output logic [AW-1:0]              sub_addr,
  output logic [$clog2(MAXLEN+1)-1:0] sub_len,
  output logic                       sub_write,
  output logic                       sub_internal,
  output logic [CW-1:0]              sub_cfg,
  input  logic                       cfg_wr_valid,
  output logic                       cfg_wr_ready,
  input  logic [RBITS-1:0]           cfg_wr_idx,
  input  logic [CW-1:0]              cfg_wr_data
);
  localparam int LW = $clog2(MAXLEN+1);
  localparam int NREG = 1 << RBITS;

  logic busy, wr, intl;
  logic [AW-1:0] addr;
  logic [LW-1:0] rem;
  logic [NREG-1:0][CW-1:0] regs;
  logic pend_v;
  logic [RBITS-1:0] pend_idx;
  logic [CW-1:0] pend_data;
  logic [2:0] room;

  wire [RBITS-1:0] ridx = addr[AW-1 -: RBITS];
  wire [CW-1:0] cur_cfg = regs[ridx];

  always_comb begin
    case (cur_cfg[1:0])
      2'd0:    room = 3'd1;
      2'd1:    room = addr[0] ? 3'd1 : 3'd2;
      default: room = 3'd4 - {1'b0, addr[1:0]};
    endcase
  end

  wire [LW-1:0] beat = intl ? rem : ((rem < LW'(room)) ? rem : LW'(room));
  wire fire = busy & sub_ready;
  wire last = fire & (beat == rem);

  assign sub_valid    = busy;
  assign sub_addr     = addr;
  assign sub_len      = beat;
  assign sub_write    = wr;
  assign sub_internal = intl;
  assign sub_cfg      = intl ? '0 : cur_cfg;
  assign req_ack      = last;
  assign cfg_wr_ready = !pend_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      wr <= 1'b0;
      intl <= 1'b0;
      addr <= '0;
      rem <= '0;
      regs <= '0;
      pend_v <= 1'b0;
      pend_idx <= '0;
      pend_data <= '0;
    end else begin
      if (!busy) begin
        if (req_valid) begin
          busy <= 1'b1;
          addr <= req_addr;
          rem  <= req_len;
          wr   <= req_write;
          intl <= ((req_addr & INT_MASK) == INT_BASE);
        end
      end else if (fire) begin
        addr <= addr + AW'(beat);
        rem  <= rem - beat;
        if (last) busy <= 1'b0;
      end

      if (!busy) begin
        if (pend_v) begin
          regs[pend_idx] <= pend_data;
          pend_v <= 1'b0;
        end else if (cfg_wr_valid) begin
          regs[cfg_wr_idx] <= cfg_wr_data;
        end
      end else if (cfg_wr_valid && !pend_v) begin
        pend_v <= 1'b1;
        pend_idx <= cfg_wr_idx;
        pend_data <= cfg_wr_data;
      end
    end
  end

  AST_ACK_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (sub_valid && sub_ready)); // R6
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !sub_ready) |=> (sub_valid && $stable(sub_addr) && $stable(sub_len))); // R10
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(regs)); // R8
  AST_BEAT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> (sub_len != 0 && sub_len <= LW'(MAXLEN))); // R2
  AST_EXT_BEAT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !sub_internal) |-> (sub_len <= LW'(4))); // R2
  AST_PEND_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr_ready && !sub_valid) |=> cfg_wr_ready); // R9
endmodule

// File: tb/tb_region_bus_splitter.sv
module tb_region_bus_splitter;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] addr;
    logic [4:0]  len;
    logic        write;
    logic        intl;
    logic [31:0] cfg;
  } beat_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_ack;
  logic [31:0] req_addr = 0;
  logic [4:0] req_len = 0;
  logic sub_valid, sub_ready = 1, sub_write, sub_internal;
  logic [31:0] sub_addr, sub_cfg;
  logic [4:0] sub_len;
  logic cfg_wr_valid = 0, cfg_wr_ready;
  logic [2:0] cfg_wr_idx = 0;
  logic [31:0] cfg_wr_data = 0;

  int checks = 0, errors = 0;
  int ready_mode = 0;
  int cyc = 0;
  logic [31:0] model [8];
  beat_t expq [$];

  region_bus_splitter dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write), .req_ack(req_ack),
    .sub_valid(sub_valid), .sub_ready(sub_ready), .sub_addr(sub_addr),
    .sub_len(sub_len), .sub_write(sub_write), .sub_internal(sub_internal),
    .sub_cfg(sub_cfg), .cfg_wr_valid(cfg_wr_valid), .cfg_wr_ready(cfg_wr_ready),
    .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    case (ready_mode)
      0: sub_ready = 1;
      1: sub_ready = cyc[0];
      default: sub_ready = 0;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n && sub_valid && sub_ready) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected beat actual=%h expected=none", sub_addr);
      end else begin
        beat_t e, a;
        e = expq.pop_front();
        a = '{sub_addr, sub_len, sub_write, sub_internal, sub_cfg};
        check("R2/R3/R5 beat", 64'(a), 64'(e));
      end
    end
  end

  task automatic push_expected(input logic [31:0] a0, input int len, input logic w);
    logic [31:0] a = a0;
    int r = len;
    if ((a0 & 32'hFF00_0000) == 32'hFF00_0000) begin
      expq.push_back('{a0, 5'(len), w, 1'b1, 32'h0});
      return;
    end
    while (r > 0) begin
      logic [31:0] c;
      int wd, n;
      c = model[a[31:29]];
      wd = (c[1:0] == 0) ? 1 : (c[1:0] == 1) ? 2 : 4;
      n = wd - int'(a % wd);
      if (n > r) n = r;
      expq.push_back('{a, 5'(n), w, 1'b0, c});
      a += n;
      r -= n;
    end
  endtask

  task automatic do_req(input logic [31:0] a, input int len, input logic w);
    push_expected(a, len, w);
    @(posedge clk); #1;
    req_valid = 1; req_addr = a; req_len = 5'(len); req_write = w;
    do @(negedge clk); while (!req_ack);
    @(posedge clk); #1;
    req_valid = 0;
    check("R6 all beats done at ack", 64'(expq.size()), 64'd0);
  endtask

  task automatic cfg_write(input logic [2:0] idx, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_wr_valid = 1; cfg_wr_idx = idx; cfg_wr_data = d;
    do @(negedge clk); while (!cfg_wr_ready);
    @(posedge clk); #1;
    cfg_wr_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 sub_valid", 64'(sub_valid), 0);
    check("R1 req_ack", 64'(req_ack), 0);
    check("R1 cfg_wr_ready", 64'(cfg_wr_ready), 1);

    // R1 reset width is 8-bit: byte beats
    do_req(32'h0000_0101, 3, 0);

    // R7 idle writes, R4 boundary crossing
    cfg_write(0, 32'h0000_A002); model[0] = 32'h0000_A002;
    cfg_write(1, 32'h0000_B002); model[1] = 32'h0000_B002;
    do_req(32'h1FFF_FFFE, 16, 1); // R4

    // R2 16-bit region with ready stalls, R3 region 5
    cfg_write(5, 32'h0000_C001); model[5] = 32'h0000_C001;
    ready_mode = 1;
    do_req(32'hA000_0003, 7, 0);
    do_req(32'h1FFF_FFFD, 9, 1);
    ready_mode = 0;

    // R5 internal window ignores region 7 register
    cfg_write(7, 32'h0000_D002); model[7] = 32'h0000_D002;
    do_req(32'hFF00_0010, 16, 0);
    do_req(32'hE000_0001, 5, 0);

    // R8 / R9 / R10: writes during an access that is held up
    ready_mode = 2;
    fork
      do_req(32'h1FFF_FFFE, 12, 0);
      begin
        logic [31:0] a1;
        logic [4:0] l1;
        repeat (3) @(negedge clk);
        a1 = sub_addr; l1 = sub_len;
        @(negedge clk);
        check("R10 valid held", 64'(sub_valid), 1);
        check("R10 addr held", 64'(sub_addr), 64'(a1));
        check("R10 len held", 64'(sub_len), 64'(l1));
        cfg_write(0, 32'h0000_0001);
        @(posedge clk); #1;
        cfg_wr_valid = 1; cfg_wr_idx = 1; cfg_wr_data = 32'h0000_0000;
        @(negedge clk);
        check("R9 second write refused", 64'(cfg_wr_ready), 0);
        ready_mode = 0;
        do @(negedge clk); while (!cfg_wr_ready);
        @(posedge clk); #1;
        cfg_wr_valid = 0;
      end
    join
    model[0] = 32'h0000_0001;
    model[1] = 32'h0000_0000;
    repeat (2) @(posedge clk);
    check("R9 ready restored", 64'(cfg_wr_ready), 1);
    do_req(32'h1FFF_FFFC, 6, 1); // R8 new words now in effect

    repeat (3) @(posedge clk);
    check("R2 queue drained", 64'(expq.size()), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule